// File: doc/BRIEF.md
# SPI Master Frame Sequencer

This block is the master side of a synchronous serial link that runs with the serial clock idling low and data sampled on its rising edge. Words that software-facing logic pushes into a four-entry transmit queue are shifted out most significant bit first on a serial output line. A word holds between 4 and 16 bits, chosen by a word-size setting. Each frame is bracketed by an active-low select line. The bits read back from the serial input during a frame are collected into a four-entry receive queue.

Every interval on the wire is counted in half periods of the serial clock. One half period is a fixed number of system clocks set by an integer divider. The select line falls half a period before the first data bit appears. The clock first rises half a period after that. Select rises again one full period after the last sample. When more words are queued, select stays high for one full period between words, and each word then repeats the same lead-in.

Top module: `spi_frame_master`

## Requirements
- R1: After reset and whenever no frame is running, `ser_clk` is 0, `sel_n` is 1, `ser_out` is 0 and `busy` is 0.
- R2: A frame starts only on a clock edge at which `enable` is 1 and the transmit queue already holds a word (a word pushed on that same edge does not count). On start, `sel_n` goes low and `ser_out_oe` goes high, and both hold for the whole frame.
- R3: The first data bit appears on `ser_out` one half period after `sel_n` falls, and `ser_clk` first rises one further half period later. While `sel_n` is low and before that first bit, `ser_out` is 0.
- R4: The frame length in bits is `word_size`+1 for `word_size` values 3 to 15. Values 0 to 2 give 4 bits. The frame sends bits [len-1:0] of the queued word, most significant first.
- R5: One half period lasts max(`divider`,1)+1 system clocks. `ser_clk` is high for one half period per bit. `ser_out` changes only while `ser_clk` is low, and `ser_in` is sampled on the clock edge at which `ser_clk` rises.
- R6: `sel_n` rises one full period (two half periods) after the rising `ser_clk` edge of the last bit. During the final half period `ser_clk` is low and `ser_out` keeps the last bit.
- R7: If, when the frame ends, `enable` is 1 and a word is queued, `sel_n` stays high for exactly two half periods. The next frame then begins with its lead-in. Otherwise the block goes idle.
- R8: Each received word holds its first sampled bit at bit len-1 and its last at bit 0, with zeros above. It enters a four-entry receive queue, and `rx_data` shows the oldest entry whenever `rx_empty` is 0. `rx_pop` removes the oldest entry; a pop on an empty queue does nothing.
- R9: A received word that arrives while the receive queue is full, with no pop accepted on that edge, is discarded and sets `rx_overrun`. The flag stays set until reset. A pop on the same edge makes room, and the word is kept.
- R10: The transmit queue holds four words, and `tx_full` reports that it is full. A push into a full queue is discarded unless a frame start removes a word on the same edge.
- R11: `ser_clk_oe` is always 1. `busy` is 1 from frame start through the inter-word gap, and therefore whenever `sel_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new frames to start |
| word_size | input | 4 | Frame length minus one (values below 3 mean 4 bits) |
| divider | input | DIV_W | Half period = max(divider,1)+1 system clocks |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 16 | Word to transmit, right-justified |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_data | output | 16 | Oldest received word, zero-extended |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Sticky flag: a received word was discarded |
| busy | output | 1 | Frame or inter-word gap in progress |
| ser_clk | output | 1 | Serial clock |
| ser_clk_oe | output | 1 | Serial clock pad enable (always on as master) |
| sel_n | output | 1 | Active-low frame select |
| ser_out | output | 1 | Serial data out |
| ser_out_oe | output | 1 | Serial data pad enable, high during a frame |
| ser_in | input | 1 | Serial data in |

## Verification
Two pairs of events can fall on the same system clock edge. On the receive side, a finished word is written into a full receive queue on the same edge as an `rx_pop`. The bench provokes this by toggling `rx_pop` pseudo-randomly while a long stream runs, and the reference model decides whether the word is kept or `rx_overrun` is set. On the transmit side, a `tx_push` can land on the edge where a frame start takes a word from the queue. Pushes into a full or empty queue during streaming produce this case, and the model judges it by the rule that the start sees the queue as it was before that edge.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    localparam int WORD_W = 16;
    localparam int LEN_W  = $clog2(WORD_W) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_GAP
    } fm_state_e;

    // Frame length in bits from the size setting; short settings clamp to 4.
    function automatic logic [LEN_W-1:0] frame_len(input logic [3:0] ws);
        if (ws < 4'd3)
            return LEN_W'(4);
        return LEN_W'(ws) + LEN_W'(1);
    endfunction

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= step(wr_ptr);
            if (do_pop)
                rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_fm_halfclk.sv
module spi_fm_halfclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divider,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    assign limit = (divider == '0) ? DIV_W'(1) : divider;
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
    import spi_fm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [3:0]        word_size,
    input  logic              tick,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    input  logic              ser_in,
    output logic              run,
    output logic              ser_clk,
    output logic              sel_n,
    output logic              ser_out
);
    fm_state_e         state;
    logic [LEN_W-1:0]  bits_left;
    logic [LEN_W-1:0]  len;
    logic [5:0]        pad;
    logic [WORD_W-1:0] tx_sh, rx_sh;
    logic              gap_second;
    logic              start_ok, load_now, in_frame, driving;

    assign len      = frame_len(word_size);
    assign pad      = 6'(WORD_W) - 6'(len);
    assign start_ok = enable && !tx_empty;
    assign load_now = (state == ST_IDLE && start_ok) ||
                      (state == ST_GAP && tick && gap_second && start_ok);
    assign tx_pop   = load_now;
    assign rx_push  = (state == ST_HIGH) && tick && (bits_left == LEN_W'(1));
    assign rx_word  = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bits_left  <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            gap_second <= 1'b0;
        end else if (load_now) begin
            state      <= ST_LEAD;
            tx_sh      <= tx_word << pad;
            rx_sh      <= '0;
            bits_left  <= len;
            gap_second <= 1'b0;
        end else if (tick) begin
            case (state)
                ST_LEAD: state <= ST_LOW;
                ST_LOW: begin
                    state <= ST_HIGH;
                    rx_sh <= {rx_sh[WORD_W-2:0], ser_in};
                end
                ST_HIGH: begin
                    if (bits_left == LEN_W'(1)) begin
                        state <= ST_TAIL;
                    end else begin
                        state     <= ST_LOW;
                        tx_sh     <= tx_sh << 1;
                        bits_left <= bits_left - LEN_W'(1);
                    end
                end
                ST_TAIL: begin
                    gap_second <= 1'b0;
                    state      <= start_ok ? ST_GAP : ST_IDLE;
                end
                ST_GAP: begin
                    if (!gap_second)
                        gap_second <= 1'b1;
                    else
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run      = (state != ST_IDLE);
    assign in_frame = (state == ST_LEAD) || (state == ST_LOW) ||
                      (state == ST_HIGH) || (state == ST_TAIL);
    assign driving  = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_TAIL);
    assign ser_clk  = (state == ST_HIGH);
    assign sel_n    = !in_frame;
    assign ser_out  = driving && tx_sh[WORD_W-1];
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import spi_fm_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [3:0]        word_size,
    input  logic [DIV_W-1:0]  divider,
    input  logic              tx_push,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_full,
    input  logic              rx_pop,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              rx_overrun,
    output logic              busy,
    output logic              ser_clk,
    output logic              ser_clk_oe,
    output logic              sel_n,
    output logic              ser_out,
    output logic              ser_out_oe,
    input  logic              ser_in
);
    logic              tx_empty, tx_pop;
    logic [WORD_W-1:0] tx_word;
    logic              rx_push, rx_full, rx_drop;
    logic [WORD_W-1:0] rx_word;
    logic              run, tick;

    spi_fm_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) i_tx_q (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .din   (tx_data),
        .pop   (tx_pop),
        .dout  (tx_word),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_fm_halfclk #(.DIV_W(DIV_W)) i_half (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .divider (divider),
        .tick    (tick)
    );

    spi_fm_engine i_eng (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .word_size (word_size),
        .tick      (tick),
        .tx_empty  (tx_empty),
        .tx_word   (tx_word),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .rx_word   (rx_word),
        .ser_in    (ser_in),
        .run       (run),
        .ser_clk   (ser_clk),
        .sel_n     (sel_n),
        .ser_out   (ser_out)
    );

    spi_fm_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) i_rx_q (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .din   (rx_word),
        .pop   (rx_pop),
        .dout  (rx_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign rx_drop = rx_push && rx_full && !(rx_pop && !rx_empty);

    always_ff @(posedge clk) begin
        if (rst)
            rx_overrun <= 1'b0;
        else if (rx_drop)
            rx_overrun <= 1'b1;
    end

    assign busy       = run;
    assign ser_clk_oe = 1'b1;
    assign ser_out_oe = !sel_n;
endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic busy,
    input logic ser_clk,
    input logic sel_n,
    input logic ser_out,
    input logic rx_overrun
);
    assert_idle_levels_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_clk && sel_n && !ser_out));

    assert_start_enabled_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_n) |-> $past(enable));

    assert_out_steady_high_R5: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_out));

    assert_clock_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> !sel_n);

    assert_select_rise_clk_low_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_n) |-> $past(!ser_clk));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> rx_overrun);

    assert_busy_in_frame_R11: assert property (@(posedge clk) disable iff (rst)
        !sel_n |-> busy);
endmodule

bind spi_frame_master spi_fm_checker i_fm_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .busy       (busy),
    .ser_clk    (ser_clk),
    .sel_n      (sel_n),
    .ser_out    (ser_out),
    .rx_overrun (rx_overrun)
);

// File: tb/test_spi_frame_master.sv
module test_spi_frame_master;
    localparam int DIV_W = 8;
    localparam int K_PLAIN = 0, K_HIGH = 1, K_TAIL = 2, K_GAP = 3;

    logic        clk = 0, rst = 1, enable = 0;
    logic [3:0]  word_size = 4'd7;
    logic [DIV_W-1:0] divider = 8'd1;
    logic        tx_push = 0, rx_pop = 0, ser_in = 0;
    logic [15:0] tx_data = '0;
    logic        tx_full, rx_empty, rx_overrun, busy;
    logic        ser_clk, ser_clk_oe, sel_n, ser_out, ser_out_oe;
    logic [15:0] rx_data;

    int nchk = 0, nfail = 0;
    bit done = 0, pop_rand = 0, drain_req = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    int txq[$], rxq[$], slots[$];
    int cnt = 0, rsh = 0;
    bit ovr = 0;

    always #5 clk = ~clk;

    spi_frame_master #(.DIV_W(DIV_W)) i_spi_frame_master (
        .clk(clk), .rst(rst), .enable(enable), .word_size(word_size),
        .divider(divider), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .rx_overrun(rx_overrun), .busy(busy),
        .ser_clk(ser_clk), .ser_clk_oe(ser_clk_oe), .sel_n(sel_n),
        .ser_out(ser_out), .ser_out_oe(ser_out_oe), .ser_in(ser_in)
    );

    function automatic int mk(int seln, int sck, int mo, int kind);
        return (kind << 4) | (seln << 2) | (sck << 1) | mo;
    endfunction

    function automatic int flen(logic [3:0] ws);
        return (ws < 3) ? 4 : int'(ws) + 1;
    endfunction

    task automatic start_word();
        int w, n;
        w = txq.pop_front();
        n = flen(word_size);
        rsh = 0;
        cnt = 0;
        slots.push_back(mk(0, 0, 0, K_PLAIN));
        for (int i = n - 1; i >= 0; i--) begin
            slots.push_back(mk(0, 0, (w >> i) & 1, K_PLAIN));
            slots.push_back(mk(0, 1, (w >> i) & 1, K_HIGH));
        end
        slots.push_back(mk(0, 0, w & 1, K_TAIL));
    endtask

    always @(posedge clk) begin
        if (rst) begin
            txq.delete(); rxq.delete(); slots.delete();
            cnt = 0; rsh = 0; ovr = 0;
        end else begin
            int h, ended;
            bit go;
            go = 0;
            h = ((divider == 0) ? 1 : int'(divider)) + 1;
            if (rx_pop && rxq.size() > 0) void'(rxq.pop_front());
            if (slots.size() > 0) begin
                cnt++;
                if (cnt == h) begin
                    cnt = 0;
                    ended = slots.pop_front();
                    if (slots.size() > 0) begin
                        if ((slots[0] >> 4) == K_HIGH) rsh = (rsh << 1) | int'(ser_in);
                        if ((slots[0] >> 4) == K_TAIL) begin
                            if (rxq.size() < 4) rxq.push_back(rsh);
                            else ovr = 1;
                        end
                    end else if ((ended >> 4) == K_TAIL) begin
                        if (enable && txq.size() > 0) begin
                            slots.push_back(mk(1, 0, 0, K_GAP));
                            slots.push_back(mk(1, 0, 0, K_GAP));
                        end
                    end else if (enable && txq.size() > 0) begin
                        go = 1;
                    end
                end
            end else if (enable && txq.size() > 0) begin
                go = 1;
            end
            if (go) start_word();
            if (tx_push && txq.size() < 4) txq.push_back(int'(tx_data));
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            int e_seln, e_sck, e_mo;
            if (slots.size() > 0) begin
                e_seln = (slots[0] >> 2) & 1;
                e_sck  = (slots[0] >> 1) & 1;
                e_mo   = slots[0] & 1;
            end else begin
                e_seln = 1; e_sck = 0; e_mo = 0;
            end
            chk("R2/R6/R7", "sel_n", int'(sel_n), e_seln);
            chk("R3/R5", "ser_clk", int'(ser_clk), e_sck);
            chk("R3/R4", "ser_out", int'(ser_out), e_mo);
            chk("R2", "ser_out_oe", int'(ser_out_oe), 1 - e_seln);
            chk("R11", "busy", int'(busy), int'(slots.size() > 0));
            chk("R11", "ser_clk_oe", int'(ser_clk_oe), 1);
            chk("R8", "rx_empty", int'(rx_empty), int'(rxq.size() == 0));
            if (rxq.size() > 0) chk("R8", "rx_data", int'(rx_data), rxq[0]);
            chk("R9", "rx_overrun", int'(rx_overrun), int'(ovr));
            chk("R10", "tx_full", int'(tx_full), int'(txq.size() == 4));
        end
    end

    // serial input and pop driver
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ser_in = lfsr[0];
            rx_pop = pop_rand ? lfsr[3] : drain_req;
        end
    end

    task automatic push_word(input logic [15:0] w);
        tx_data = w;
        tx_push = 1;
        @(negedge clk);
        tx_push = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            if (slots.size() == 0 && !(enable && txq.size() > 0)) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic drain();
        drain_req = 1;
        repeat (6) @(negedge clk);
        drain_req = 0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: levels after reset
        chk("R1", "sel_n idle", int'(sel_n), 1);
        chk("R1", "ser_clk idle", int'(ser_clk), 0);
        chk("R1", "ser_out idle", int'(ser_out), 0);
        chk("R1", "busy idle", int'(busy), 0);

        // R2: queued words do not start while disabled
        word_size = 4'd7; divider = 8'd1;
        push_word(16'h00A5);
        push_word(16'h003C);
        repeat (20) @(negedge clk);
        chk("R2", "busy while disabled", int'(busy), 0);
        chk("R2", "sel_n while disabled", int'(sel_n), 1);
        enable = 1;
        wait_idle();
        drain();

        // R7: 16-bit back-to-back stream, refilled while running
        word_size = 4'd15; divider = 8'd2;
        push_word(16'hBEEF);
        push_word(16'h8001);
        push_word(16'h7FFE);
        repeat (40) @(negedge clk);
        push_word(16'h1234);
        wait_idle();
        drain();

        // R4: short words, clamped size, minimum divider (R5)
        divider = 8'd0; word_size = 4'd3;
        push_word(16'h000A);
        wait_idle();
        word_size = 4'd0;
        push_word(16'hFFF5);
        wait_idle();
        drain();

        // R10: fill the transmit queue while disabled, extra pushes dropped
        enable = 0; divider = 8'd1; word_size = 4'd4;
        for (int i = 0; i < 6; i++) push_word(16'(i * 7 + 3));
        @(negedge clk);
        chk("R10", "tx_full after overfill", int'(tx_full), 1);
        enable = 1;
        wait_idle();
        // R9: receive queue is full now; two more words overrun
        push_word(16'h0011);
        push_word(16'h0016);
        wait_idle();
        chk("R9", "overrun set", int'(rx_overrun), 1);
        drain();

        // R8 R9: random pops racing receive pushes during a long stream
        pop_rand = 1; word_size = 4'd11; divider = 8'd1;
        for (int i = 0; i < 10; i++) begin
            while (tx_full) @(negedge clk);
            push_word(16'(16'h0F0F ^ (i * 16'h0123)));
        end
        wait_idle();
        pop_rand = 0;
        drain();

        // R7: disable mid-stream, current word finishes then idle
        word_size = 4'd8; divider = 8'd3;
        push_word(16'h0155);
        push_word(16'h00AA);
        push_word(16'h01C3);
        repeat (30) @(negedge clk);
        enable = 0;
        wait_idle();
        chk("R7", "idle after disable", int'(busy), 0);
        enable = 1;
        wait_idle();
        drain();

        done = 1;
        summary();
    end
endmodule